// File: doc/BRIEF.md
# Nibble-to-Byte Flash Write Collector

This block sits between a narrow CPU window that moves one 4-bit nibble per bus access and a byte-organised flash array split into four banks. The CPU builds each flash byte in two accesses. The first nibble goes into a holding register. The second nibble joins it, and the pair goes out as a single byte-program request over a simple request/acknowledge handshake. Reads are combinational. The block forms the flash byte address from the bus address and returns the addressed half of the stored byte.

Each bank has its own 4 KB window. Only 512 nibble positions in a window are distinct, and the rest of the window repeats them. An external unlock input gates every write. When unlock is low a write changes nothing, and the block gives no indication that it happened. While one program request waits for its acknowledge, a single further commit can be parked. It is issued as soon as the running request is acknowledged.

Top module: `nibcol_flash_collector`

## Requirements
- R1: After reset, `fl_req` and `busy` are low, no commit is parked, and the holding register holds zero.
- R2: An unlocked write with `bus_addr[1]`=0 loads `bus_wdata` into the holding register and raises no request.
- R3: An unlocked write with `bus_addr[1]`=1 raises `fl_req` one cycle later. `fl_wdata` carries the held nibble in bits [7:4] and the written nibble in bits [3:0]. `fl_addr` is {`bus_addr[13:12]` bank, `bus_addr[9:2]` byte index}.
- R4: A write while `unlock` is low leaves the holding register unchanged, raises no request and changes no flash byte.
- R5: `bus_addr[0]` is ignored, so an odd-byte access acts like the even one below it.
- R6: `bus_addr[11:10]` are ignored for reads and writes, so each 1 KB span repeats four times inside a bank window.
- R7: `fl_raddr` equals {bank, byte index}. `bus_rdata` returns `fl_rdata[7:4]` when `bus_addr[1]`=0 and `fl_rdata[3:0]` when it is 1. The holding register is never visible on reads.
- R8: A commit that has no new first nibble before it reuses the last held nibble as the high half.
- R9: `fl_req` stays high with stable `fl_addr` and `fl_wdata` until the cycle in which `fl_ack` is high. `busy` is high whenever a request is open or a commit is parked.
- R10: A commit that arrives while a request is open and the park slot is empty is parked. It becomes the request in the cycle after the acknowledge.
- R11: A commit that arrives while a request is open and a commit is already parked is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unlock | input | 1 | Write enable gate |
| bus_wr | input | 1 | One-cycle bus write strobe |
| bus_addr | input | 14 | Bank (13:12) and offset in the 4 KB window |
| bus_wdata | input | 4 | Written nibble |
| bus_rdata | output | 4 | Read nibble |
| fl_raddr | output | 10 | Flash read byte address |
| fl_rdata | input | 8 | Flash read byte |
| fl_req | output | 1 | Byte program request |
| fl_addr | output | 10 | Program byte address |
| fl_wdata | output | 8 | Program byte data |
| fl_ack | input | 1 | Program acknowledge |
| busy | output | 1 | Request open or commit parked |

## Verification
The byte-building path is exercised with nibble pairs placed in every bank, at both ends and in the middle of the byte index range. The pairs use different mirror bits and both parities of address bit 0. This separates a wrong bank or byte field from a wrong mirror decode, and it shows whether the two halves are swapped. Further commits come with no fresh first nibble, with a locked first nibble in front of them, and with the lock applied to the commit itself. These cases show whether the held value persists, whether the gate covers both halves, and whether a commit is wrongly dropped. A final burst of three commits against a slow acknowledge tells parking apart from overwriting and from discarding.

// File: rtl/nibcol_pkg.sv
package nibcol_pkg;
    typedef enum logic {
        HALF_HI = 1'b0,
        HALF_LO = 1'b1
    } half_e;
endpackage

// File: rtl/nibcol_decode.sv
module nibcol_decode
    import nibcol_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int BYTE_W = 8,
    parameter int WIN_W  = 12
) (
    input  logic [BANK_W+WIN_W-1:0] addr,
    output logic [BANK_W-1:0]       bank,
    output logic [BYTE_W-1:0]       byte_idx,
    output half_e                   half
);
    // bits above the nibble span are mirror bits; bit 0 selects odd/even byte
    logic unused_bits;

    assign bank        = addr[BANK_W+WIN_W-1:WIN_W];
    assign byte_idx    = addr[BYTE_W+1:2];
    assign half        = half_e'(addr[1]);
    assign unused_bits = ^{addr[WIN_W-1:BYTE_W+2], addr[0]};
endmodule

// File: rtl/nibcol_hold.sv
module nibcol_hold #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NIB_W-1:0] din,
    output logic [NIB_W-1:0] hold
);
    typedef struct packed {
        logic [NIB_W-1:0] nib;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.nib = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold = hold_q.nib;
endmodule

// File: rtl/nibcol_prog.sv
module nibcol_prog #(
    parameter int FA_W   = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [FA_W-1:0]   commit_addr,
    input  logic [DATA_W-1:0] commit_data,
    input  logic              ack,
    output logic              req,
    output logic [FA_W-1:0]   req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              busy
);
    typedef struct packed {
        logic              req;
        logic [FA_W-1:0]   addr;
        logic [DATA_W-1:0] data;
        logic              pend_v;
        logic [FA_W-1:0]   pend_addr;
        logic [DATA_W-1:0] pend_data;
    } prog_t;

    prog_t st_d, st_q;
    logic  free;

    always_comb begin
        st_d = st_q;
        free = !st_q.req || ack;
        if (free) begin
            if (st_q.pend_v) begin
                st_d.req       = 1'b1;
                st_d.addr      = st_q.pend_addr;
                st_d.data      = st_q.pend_data;
                st_d.pend_v    = commit;
                st_d.pend_addr = commit_addr;
                st_d.pend_data = commit_data;
            end else if (commit) begin
                st_d.req  = 1'b1;
                st_d.addr = commit_addr;
                st_d.data = commit_data;
            end else begin
                st_d.req = 1'b0;
            end
        end else if (commit && !st_q.pend_v) begin
            st_d.pend_v    = 1'b1;
            st_d.pend_addr = commit_addr;
            st_d.pend_data = commit_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req      = st_q.req;
    assign req_addr = st_q.addr;
    assign req_data = st_q.data;
    assign busy     = st_q.req | st_q.pend_v;
endmodule

// File: rtl/nibcol_flash_collector.sv
module nibcol_flash_collector
    import nibcol_pkg::*;
#(
    parameter  int BANKS         = 4,
    parameter  int NIBS_PER_BANK = 512,
    parameter  int WINDOW_BYTES  = 4096,
    parameter  int NIB_W         = 4,
    localparam int BANK_W        = $clog2(BANKS),
    localparam int BYTE_W        = $clog2(NIBS_PER_BANK / 2),
    localparam int WIN_W         = $clog2(WINDOW_BYTES),
    localparam int ADDR_W        = BANK_W + WIN_W,
    localparam int FA_W          = BANK_W + BYTE_W,
    localparam int DATA_W        = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NIB_W-1:0]  bus_wdata,
    output logic [NIB_W-1:0]  bus_rdata,
    output logic [FA_W-1:0]   fl_raddr,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              fl_req,
    output logic [FA_W-1:0]   fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_ack,
    output logic              busy
);
    logic [BANK_W-1:0] bank;
    logic [BYTE_W-1:0] byte_idx;
    half_e             half;
    logic              wr_ok;
    logic              load_hi;
    logic              commit;
    logic [NIB_W-1:0]  hold;

    nibcol_decode #(
        .BANK_W (BANK_W),
        .BYTE_W (BYTE_W),
        .WIN_W  (WIN_W)
    ) u_dec (
        .addr     (bus_addr),
        .bank     (bank),
        .byte_idx (byte_idx),
        .half     (half)
    );

    assign wr_ok   = bus_wr & unlock;
    assign load_hi = wr_ok & (half == HALF_HI);
    assign commit  = wr_ok & (half == HALF_LO);

    nibcol_hold #(
        .NIB_W (NIB_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_hi),
        .din   (bus_wdata),
        .hold  (hold)
    );

    nibcol_prog #(
        .FA_W   (FA_W),
        .DATA_W (DATA_W)
    ) u_prog (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_addr ({bank, byte_idx}),
        .commit_data ({hold, bus_wdata}),
        .ack         (fl_ack),
        .req         (fl_req),
        .req_addr    (fl_addr),
        .req_data    (fl_wdata),
        .busy        (busy)
    );

    assign fl_raddr  = {bank, byte_idx};
    assign bus_rdata = (half == HALF_HI) ? fl_rdata[DATA_W-1:NIB_W] : fl_rdata[NIB_W-1:0];
endmodule

// File: rtl/nibcol_checker.sv
module nibcol_checker #(
    parameter int ADDR_W = 14,
    parameter int FA_W   = 10,
    parameter int NIB_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              unlock,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NIB_W-1:0]  bus_wdata,
    input logic              fl_req,
    input logic [FA_W-1:0]   fl_addr,
    input logic [2*NIB_W-1:0] fl_wdata,
    input logic              fl_ack,
    input logic              busy
);
    a_r9_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_ack |=> fl_req && $stable(fl_addr) && $stable(fl_wdata));

    a_r9_busy_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> busy);

    a_r4_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !(bus_wr && unlock) |=> !fl_req);

    a_r2_first_half_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && bus_wr && unlock && !bus_addr[1] |=> !fl_req);

    a_r3_commit_issues: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && bus_wr && unlock && bus_addr[1] |=> fl_req && fl_wdata[NIB_W-1:0] == $past(bus_wdata));
endmodule

bind nibcol_flash_collector nibcol_checker #(
    .ADDR_W (ADDR_W),
    .FA_W   (FA_W),
    .NIB_W  (NIB_W)
) u_chk (.*);

// File: tb/nibcol_flash_collector_tb.sv
module nibcol_flash_collector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unlock = 1'b0;
    logic        bus_wr = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [3:0]  bus_wdata = '0;
    logic [3:0]  bus_rdata;
    logic [9:0]  fl_raddr;
    logic [7:0]  fl_rdata;
    logic        fl_req;
    logic [9:0]  fl_addr;
    logic [7:0]  fl_wdata;
    logic        fl_ack = 1'b0;
    logic        busy;
    logic [7:0]  mem [1024];
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    nibcol_flash_collector u_dut (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 1024; k++) mem[k] <= 8'hFF;
        end else if (fl_req && fl_ack) begin
            mem[fl_addr] <= fl_wdata;
        end
    end
    assign fl_rdata = mem[fl_raddr];

    // {first addr[13:0], hi[3:0], lo[3:0], expected flash addr[9:0], expected byte[7:0]}
    localparam logic [39:0] VEC [6] = '{
        {14'h0000, 4'h1, 4'h2, 10'h000, 8'h12},
        {14'h1014, 4'hA, 4'hB, 10'h105, 8'hAB},
        {14'h2FFD, 4'h7, 4'hC, 10'h2FF, 8'h7C},
        {14'h3600, 4'h0, 4'hF, 10'h380, 8'h0F},
        {14'h08CC, 4'hE, 4'h4, 10'h033, 8'hE4},
        {14'h2004, 4'h9, 4'h6, 10'h201, 8'h96}
    };

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [3:0] d, input logic ul);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; unlock = ul;
        @(negedge clk);
        bus_wr = 1'b0; unlock = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        fl_ack = 1'b1;
        @(negedge clk);
        fl_ack = 1'b0;
    endtask

    task automatic rd(input string r, input logic [13:0] a, input logic [3:0] e);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(r, bus_rdata, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req", fl_req, 0);
        chk("R1 busy", busy, 0);

        // R1 / R8: commit with nothing buffered uses reset value zero
        wr(14'h0042, 4'h5, 1'b1);
        chk("R8 data", fl_wdata, 8'h05);
        ack();

        for (int i = 0; i < 6; i++) begin
            logic [39:0] v;
            v = VEC[i];
            wr(v[39:26], v[25:22], 1'b1);
            chk("R2 no req", fl_req, 0);
            wr(v[39:26] | 14'h2, v[21:18], 1'b1);
            chk("R3 req", fl_req, 1);
            chk("R3 R5 R6 addr", fl_addr, v[17:8]);
            chk("R3 data", fl_wdata, v[7:0]);
            ack();
            chk("R9 released", fl_req, 0);
            rd("R7 R6 hi", v[39:26] ^ 14'h0400, v[7:4]);
            rd("R7 R6 lo", (v[39:26] | 14'h2) ^ 14'h0800, v[3:0]);
        end

        // R8: hold is still 9 from last vector
        wr(14'h0046, 4'h1, 1'b1);
        chk("R8 reuse", fl_wdata, 8'h91);
        ack();

        // R4: locked writes
        wr(14'h0048, 4'h3, 1'b0);
        wr(14'h004A, 4'h2, 1'b0);
        chk("R4 no req", fl_req, 0);
        rd("R4 flash untouched", 14'h0048, 4'hF);
        wr(14'h004A, 4'h2, 1'b1);
        chk("R4 hold kept", fl_wdata, 8'h92);
        ack();

        // R7: buffered nibble not visible
        wr(14'h0050, 4'hD, 1'b1);
        rd("R7 hold hidden", 14'h0050, 4'hF);

        // R10 / R11: park and discard
        wr(14'h0052, 4'h1, 1'b1);
        wr(14'h0056, 4'h2, 1'b1);
        chk("R10 busy", busy, 1);
        chk("R9 data held", fl_wdata, 8'hD1);
        chk("R9 addr held", fl_addr, 10'h014);
        wr(14'h005A, 4'h3, 1'b1);
        ack();
        chk("R10 parked req", fl_req, 1);
        chk("R10 parked addr", fl_addr, 10'h015);
        chk("R10 parked data", fl_wdata, 8'hD2);
        ack();
        chk("R11 req done", fl_req, 0);
        chk("R11 busy done", busy, 0);
        rd("R11 dropped", 14'h005A, 4'hF);
        rd("R10 written", 14'h0056, 4'h2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule